// File: doc/BRIEF.md
# Inverted-mask logic execute unit

This unit executes one scalar integer operation: it clears, in the second source operand, every bit that is set in the first source operand. Put another way, it computes the complement of operand A ANDed with operand B. The operand width is chosen from the current processor mode and a decoded width-select bit. The unit produces a sized 64-bit destination value and the status flags that go with it. Each flag has its own update-mask bit.

Some encodings are invalid: a set vector-length bit, or a processor mode that does not support the operation. For these, the unit raises an undefined-opcode strobe instead of a write. When it faults, it commits neither a register nor any flag.

A two-state control machine connects a valid/ready input port to a single output register stage. It has two states:

- **EMPTY**: the output stage holds nothing.
- **HOLD**: the output stage holds a result.

It has four transitions:

- **ACCEPT** (EMPTY to HOLD): `in_valid` is high while the unit is empty.
- **RELOAD** (HOLD to HOLD): the consumer takes the result and a new input is accepted in the same cycle.
- **DRAIN** (HOLD to EMPTY): the consumer takes the result and no new input arrives.
- **STALL** (HOLD to HOLD): `out_ready` is low.

Processor mode encoding on `cpu_mode`:

| Code | Mode |
|------|------|
| 2'b00 | 16-bit mode |
| 2'b01 | 32-bit protected or compatibility mode |
| 2'b10 | 64-bit long mode |
| 2'b11 | Reserved; handled like 16-bit mode |

Flag bit positions on `flags` and `flag_mask`:

| Bit | Flag |
|-----|------|
| 0 | carry |
| 1 | parity |
| 2 | auxiliary |
| 3 | zero |
| 4 | sign |
| 5 | overflow |

Top module: `bitclr_exec`

## Requirements
- R1: In mode 2'b10 with `wide_sel`=1, `dest_data` equals `~src_a & src_b` over all 64 bits.
- R2: In mode 2'b01 the operation is 32 bits wide whatever `wide_sel` is. `dest_data[31:0]` is `~src_a[31:0] & src_b[31:0]`, and `dest_data[63:32]` is zero.
- R3: In mode 2'b10 with `wide_sel`=0 the operation is 32 bits wide, and the upper 32 bits of `dest_data` are zero.
- R4: When `vec_len`=1, the result raises `ud_fault` and leaves `dest_we` low. `flag_mask`, `flags` and `dest_data` are all zero.
- R5: Mode codes 2'b00 and 2'b11 raise `ud_fault` with the same zeroed outputs as R4.
- R6: On a committed result, carry (bit 0) and overflow (bit 5) are 0.
- R7: On a committed result, zero (bit 3) is 1 exactly when the sized result is all zeros.
- R8: On a committed result, sign (bit 4) equals bit 63 of the result for a 64-bit operation and bit 31 for a 32-bit operation.
- R9: On a committed result, `flag_mask` is 6'b111001: carry, zero, sign and overflow are written. Parity and auxiliary have mask 0 and value 0, so the consumer keeps their earlier values.
- R10: Outputs become valid in the cycle after an input is accepted. They are held unchanged while `out_ready` is low. While they are stalled, `in_ready` is low.
- R11: `dest_we` and `ud_fault` are never high together, and each is high only while `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operation present |
| in_ready | output | 1 | Unit can accept an input this cycle |
| src_a | input | 64 | Operand whose complement is used as the mask |
| src_b | input | 64 | Operand passed through unchanged |
| wide_sel | input | 1 | Decoded width-select bit |
| vec_len | input | 1 | Decoded vector-length bit; 1 is invalid |
| cpu_mode | input | 2 | Processor mode code |
| out_valid | output | 1 | Result stage holds an item |
| out_ready | input | 1 | Consumer takes the item |
| dest_data | output | 64 | Sized, zero-extended result |
| dest_we | output | 1 | Destination register write enable |
| flags | output | 6 | Flag values |
| flag_mask | output | 6 | Flag update mask |
| ud_fault | output | 1 | Undefined-opcode strobe |

## Verification
Directed operands exercise each width path separately:

- Operands with set upper bits, run under the 32-bit widths, show whether the upper half is zero-extended.
- Operands with bit 31 set but bit 63 clear separate a 31-bit sign tap from a 63-bit one.
- A result that is zero only in the low half shows whether the zero flag looks at the sized result.

Beyond the directed cases:

- Every mode code is driven with the width bit both set and cleared, with and without the vector-length bit, to check the fault decode.
- Random operands are run under random back-pressure, so that back-to-back reloads, stalls and drains all occur.

// File: rtl/bitclr_pkg.sv
package bitclr_pkg;
    localparam int FLAG_W = 6;
    localparam int FL_CARRY = 0;
    localparam int FL_PARITY = 1;
    localparam int FL_AUX = 2;
    localparam int FL_ZERO = 3;
    localparam int FL_SIGN = 4;
    localparam int FL_OVER = 5;
    localparam logic [FLAG_W-1:0] FLAG_WRITE_MASK =
        (FLAG_W'(1) << FL_CARRY) | (FLAG_W'(1) << FL_ZERO) |
        (FLAG_W'(1) << FL_SIGN) | (FLAG_W'(1) << FL_OVER);

    typedef enum logic [1:0] {
        MODE_16 = 2'b00,
        MODE_32 = 2'b01,
        MODE_64 = 2'b10,
        MODE_RSVD = 2'b11
    } cpu_mode_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HOLD = 1'b1
    } pipe_state_e;
endpackage

// File: rtl/bitclr_size_dec.sv
module bitclr_size_dec
    import bitclr_pkg::*;
(
    input  logic [1:0] cpu_mode,
    input  logic       wide_sel,
    input  logic       vec_len,
    output logic       op_wide,
    output logic       fault
);
    logic mode_ok;
    logic mode_long;

    always_comb begin
        mode_ok = 1'b0;
        mode_long = 1'b0;
        unique case (cpu_mode_e'(cpu_mode))
            MODE_16: begin
                mode_ok = 1'b0;
                mode_long = 1'b0;
            end
            MODE_32: begin
                mode_ok = 1'b1;
                mode_long = 1'b0;
            end
            MODE_64: begin
                mode_ok = 1'b1;
                mode_long = 1'b1;
            end
            MODE_RSVD: begin
                mode_ok = 1'b0;
                mode_long = 1'b0;
            end
        endcase
    end

    // The width bit only matters in long mode; elsewhere it is ignored.
    assign op_wide = mode_long & wide_sel;
    assign fault = vec_len | ~mode_ok;
endmodule

// File: rtl/bitclr_datapath.sv
module bitclr_datapath
    import bitclr_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              op_wide,
    input  logic              fault,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flag_val,
    output logic [FLAG_W-1:0] flag_wr,
    output logic              wr_en,
    output logic              ud
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] full_res;
    logic [DATA_W-1:0] sized_res;
    logic              zero_hit;
    logic              sign_bit;

    assign full_res = ~src_a & src_b;

    // The lower half always passes; the upper half is kept only for a wide operation.
    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_lane
            if (gi < HALF_W) begin : g_low
                assign sized_res[gi] = full_res[gi];
            end else begin : g_high
                assign sized_res[gi] = full_res[gi] & op_wide;
            end
        end
    endgenerate

    assign zero_hit = op_wide ? (sized_res == '0) : (sized_res[HALF_W-1:0] == '0);
    assign sign_bit = op_wide ? sized_res[DATA_W-1] : sized_res[HALF_W-1];

    always_comb begin
        result = '0;
        flag_val = '0;
        flag_wr = '0;
        wr_en = 1'b0;
        ud = 1'b0;
        if (fault) begin
            ud = 1'b1;
        end else begin
            wr_en = 1'b1;
            result = sized_res;
            flag_wr = FLAG_WRITE_MASK;
            flag_val[FL_ZERO] = zero_hit;
            flag_val[FL_SIGN] = sign_bit;
        end
    end
endmodule

// File: rtl/bitclr_ctrl.sv
module bitclr_ctrl
    import bitclr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic load,
    output logic out_valid
);
    pipe_state_e state_q;
    pipe_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        in_ready = 1'b0;
        load = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                in_ready = 1'b1;
                load = in_valid;
                if (in_valid) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                out_valid = 1'b1;
                in_ready = out_ready;
                load = in_valid & out_ready;
                if (out_ready && !in_valid) begin
                    state_d = ST_EMPTY;
                end
            end
        endcase
    end
endmodule

// File: rtl/bitclr_exec.sv
module bitclr_exec
    import bitclr_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              wide_sel,
    input  logic              vec_len,
    input  logic [1:0]        cpu_mode,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] dest_data,
    output logic              dest_we,
    output logic [5:0]        flags,
    output logic [5:0]        flag_mask,
    output logic              ud_fault
);
    logic              op_wide;
    logic              fault;
    logic [DATA_W-1:0] result;
    logic [FLAG_W-1:0] flag_val;
    logic [FLAG_W-1:0] flag_wr;
    logic              wr_en;
    logic              ud;
    logic              load;
    logic              valid_int;

    logic [DATA_W-1:0] data_q;
    logic [FLAG_W-1:0] flag_q;
    logic [FLAG_W-1:0] mask_q;
    logic              we_q;
    logic              ud_q;

    bitclr_size_dec u_dec (
        .cpu_mode (cpu_mode),
        .wide_sel (wide_sel),
        .vec_len  (vec_len),
        .op_wide  (op_wide),
        .fault    (fault)
    );

    bitclr_datapath #(.DATA_W(DATA_W)) u_dp (
        .src_a    (src_a),
        .src_b    (src_b),
        .op_wide  (op_wide),
        .fault    (fault),
        .result   (result),
        .flag_val (flag_val),
        .flag_wr  (flag_wr),
        .wr_en    (wr_en),
        .ud       (ud)
    );

    bitclr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .load      (load),
        .out_valid (valid_int)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            flag_q <= '0;
            mask_q <= '0;
            we_q <= 1'b0;
            ud_q <= 1'b0;
        end else if (load) begin
            data_q <= result;
            flag_q <= flag_val;
            mask_q <= flag_wr;
            we_q <= wr_en;
            ud_q <= ud;
        end
    end

    assign out_valid = valid_int;
    assign dest_data = data_q;
    assign flags = flag_q;
    assign flag_mask = mask_q;
    assign dest_we = valid_int & we_q;
    assign ud_fault = valid_int & ud_q;
endmodule

// File: rtl/bitclr_exec_chk.sv
module bitclr_exec_chk
    import bitclr_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] dest_data,
    input logic              dest_we,
    input logic [5:0]        flags,
    input logic [5:0]        flag_mask,
    input logic              ud_fault
);
    // R11
    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(dest_we && ud_fault));
    // R11
    p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dest_we || ud_fault) |-> out_valid);
    // R6
    p_cfof_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dest_we |-> (!flags[FL_CARRY] && !flags[FL_OVER]));
    // R7
    p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dest_we |-> (flags[FL_ZERO] == (dest_data == '0)));
    // R8
    p_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dest_we && dest_data[DATA_W-1]) |-> flags[FL_SIGN]);
    // R9
    p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dest_we |-> (flag_mask == 6'b111001));
    // R4
    p_fault_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ud_fault |-> (flag_mask == '0 && flags == '0 && dest_data == '0));
    // R10
    p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
    // R10
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(dest_data) &&
            $stable(flags) && $stable(flag_mask) && $stable(ud_fault)));
    // R10
    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
endmodule

bind bitclr_exec bitclr_exec_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .dest_data (dest_data),
    .dest_we   (dest_we),
    .flags     (flags),
    .flag_mask (flag_mask),
    .ud_fault  (ud_fault)
);

// File: tb/bitclr_exec_tb_top.sv
module bitclr_exec_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        wide_sel = 1'b0;
    logic        vec_len = 1'b0;
    logic [1:0]  cpu_mode = 2'b00;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] dest_data;
    logic        dest_we;
    logic [5:0]  flags;
    logic [5:0]  flag_mask;
    logic        ud_fault;

    typedef struct {
        logic [63:0] data;
        logic        we;
        logic        ud;
        logic [5:0]  fl;
        logic [5:0]  mk;
        int          stamp;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_checks = 0;
    int   n_fails = 0;
    int   cyc = 0;
    bit   stall_mode = 1'b0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    bitclr_exec dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .src_a     (src_a),
        .src_b     (src_b),
        .wide_sel  (wide_sel),
        .vec_len   (vec_len),
        .cpu_mode  (cpu_mode),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .dest_data (dest_data),
        .dest_we   (dest_we),
        .flags     (flags),
        .flag_mask (flag_mask),
        .ud_fault  (ud_fault)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        #2;
        out_ready = stall_mode ? ($urandom % 3 != 0) : 1'b1;
    end

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic exp_t model(input logic [63:0] a, input logic [63:0] b,
                                   input logic w, input logic l, input logic [1:0] m);
        exp_t e;
        logic wide;
        logic [63:0] r;
        wide = (m == 2'b10) && w;
        r = ~a & b;
        if (!wide) r[63:32] = '0;
        e.data = '0; e.fl = '0; e.mk = '0; e.we = 1'b0; e.ud = 1'b0;
        e.stamp = 0; e.tag = "";
        if (l || !(m == 2'b01 || m == 2'b10)) begin
            e.ud = 1'b1;
        end else begin
            e.we = 1'b1;
            e.data = r;
            e.fl[3] = wide ? (r == '0) : (r[31:0] == '0);
            e.fl[4] = wide ? r[63] : r[31];
            e.mk = 6'b111001;
        end
        return e;
    endfunction

    task automatic push_op(input logic [63:0] a, input logic [63:0] b, input logic w,
                           input logic l, input logic [1:0] m, input string tag);
        exp_t e;
        @(negedge clk);
        src_a = a; src_b = b; wide_sel = w; vec_len = l; cpu_mode = m;
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        e = model(a, b, w, l, m);
        e.stamp = cyc;
        e.tag = tag;
        sb_q.push_back(e);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid && !out_ready)
                check(in_ready == 1'b0, "R10 input ready during stall", 128'(in_ready), 128'(0));
            if (sb_q.size() > 0 && cyc > sb_q[0].stamp && !out_valid)
                check(1'b0, "R10 result late", 128'(out_valid), 128'(1));
            if (out_valid && out_ready) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R10 unexpected output", 128'(out_valid), 128'(0));
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(dest_data == e.data, {e.tag, " data"}, 128'(dest_data), 128'(e.data));
                    check(flags == e.fl, {e.tag, " flags R6 R7 R8"}, 128'(flags), 128'(e.fl));
                    check(flag_mask == e.mk, {e.tag, " mask R9"}, 128'(flag_mask), 128'(e.mk));
                    check({dest_we, ud_fault} == {e.we, e.ud}, {e.tag, " we/fault R11"},
                          128'({dest_we, ud_fault}), 128'({e.we, e.ud}));
                end
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 50000 && !done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R10 watchdog expired with %0d items pending", sb_q.size());
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0 && dest_we == 1'b0 && ud_fault == 1'b0, "R11 reset state",
              128'({out_valid, dest_we, ud_fault}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R10 ready after reset", 128'(in_ready), 128'(1));

        push_op(64'h00FF_00FF_F0F0_0F0F, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 2'b10, "R1 wide");
        push_op(64'h0000_0000_0000_0000, 64'h8000_0000_0000_0001, 1, 0, 2'b10, "R8 sign63");
        push_op(64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0000, 1, 0, 2'b10, "R7 zero64");
        push_op(64'h0000_0000_FFFF_FFFF, 64'hDEAD_BEEF_0000_0000, 0, 0, 2'b10, "R3 narrow64 R7");
        push_op(64'h1234_5678_0000_0000, 64'hFFFF_FFFF_8000_0000, 0, 0, 2'b10, "R3 R8 sign31");
        push_op(64'h0000_0000_0000_00FF, 64'hFFFF_FFFF_1234_5678, 1, 0, 2'b01, "R2 w-ignored");
        push_op(64'h0000_0000_0000_00FF, 64'hFFFF_FFFF_1234_5678, 0, 0, 2'b01, "R2 w0");
        push_op(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 2'b10, "R4 veclen");
        push_op(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 2'b01, "R4 veclen32");
        push_op(64'h0, 64'h0000_0000_0000_0001, 0, 0, 2'b00, "R5 mode16");
        push_op(64'h0, 64'h0000_0000_0000_0001, 1, 0, 2'b11, "R5 rsvd");
        push_op(64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 2'b10, "R1 R6 R9");

        stall_mode = 1'b1;
        for (int i = 0; i < 200; i++) begin
            logic [63:0] ra;
            logic [63:0] rb;
            logic [1:0]  rm;
            logic        rw;
            logic        rl;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            rm = 2'($urandom);
            rw = 1'($urandom);
            rl = ($urandom % 8 == 0);
            push_op(ra, rb, rw, rl, rm, "R10 random");
        end
        stall_mode = 1'b0;
        while (sb_q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R10 drained", 128'(out_valid), 128'(0));
        finish_run();
    end
endmodule